// File: doc/BRIEF.md
# Oscillator Switch-over Sequencer

This block decides which oscillator drives the system clock. It can move between a slow secondary oscillator and the fast path, which is the main oscillator or, in the multiplied crystal mode, the PLL output. Software drives a select input. Setting it moves the system clock to the secondary oscillator. Clearing it starts a move back to the fast path.

The move back is not immediate. The select input is first synchronised into the main-clock domain. A counter clocked by the main oscillator then waits for a time that depends on the mode. RC and external-clock modes wait eight cycles. Crystal modes wait 1024 cycles. The PLL crystal mode adds a parameterised lock wait after those 1024 cycles.

The secondary oscillator keeps clocking the system for the whole wait. The handover uses a glitch-free multiplexer with two enables. Each enable is synchronised to its own clock and changes on that clock's falling edge. Each enable is allowed to rise only once the other one has dropped. When a handover completes, a one-cycle done pulse appears in the domain of the new clock. A status output shows whether the fast path is the source gated onto the system clock.

Top module: `osc_switch_seq`

## Requirements
- R1: Reset (`rst_n` low) selects the fast path with the wait counter cleared. After release with `sel_sec` = 0, `src_is_main` = 1 and `switch_done` = 0. `sys_clk` runs at the main-clock period, or at the PLL-clock period when `mode` = 3'b101.
- R2: After `sel_sec` rises, `switch_done` pulses within 4 secondary periods plus 6 main periods. From then on `src_is_main` = 0 and `sys_clk` runs at the secondary period.
- R3: In `mode` 3'b000, 3'b001, 3'b010 and 3'b011, clearing `sel_sec` starts a count of RC_CYC = 8 main cycles. `src_is_main` rises no earlier than 8 main periods after the clear and no later than 8 main periods plus 4 secondary periods plus 6 main periods.
- R4: In `mode` 3'b100 the wait is OST_CYC main cycles, with the same lower and upper bounds as in R3 for N = OST_CYC. After it, `sys_clk` runs at the main period.
- R5: In `mode` 3'b101 the wait is OST_CYC + LOCK_CYC main cycles, with the same bounds. After it, `sys_clk` runs at the PLL-clock period.
- R6: During the whole wait and the handover, `sys_clk` keeps toggling. No interval between its rising edges exceeds one secondary period.
- R7: No high or low phase of `sys_clk` is shorter than the shorter half period of the two sources involved in a move.
- R8: Each completed handover gives exactly one `switch_done` pulse. The pulse lasts one period of the newly selected clock.
- R9: If `sel_sec` returns to 1 before the wait ends, the wait is aborted and `sys_clk` stays on the secondary oscillator. `src_is_main` does not rise and `switch_done` stays low. A later clear restarts the full wait from zero.
- R10: The reserved mode codes 3'b110 and 3'b111 wait OST_CYC cycles, like 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_clk | input | 1 | Low-frequency secondary oscillator |
| main_clk | input | 1 | Main oscillator |
| pll_clk | input | 1 | Multiplied clock from the PLL |
| mode | input | 3 | Oscillator mode: 000 RC, 001 RC with I/O, 010 external, 011 external with I/O, 100 crystal, 101 crystal with PLL, 110/111 treated as crystal |
| sel_sec | input | 1 | Clock select: 1 secondary, 0 fast path |
| sys_clk | output | 1 | Gated system clock |
| switch_done | output | 1 | One-cycle pulse in the new clock domain when a handover completes |
| src_is_main | output | 1 | 1 while the fast path is gated onto sys_clk |

## Verification
A counter that starts from a wrong value shows up at `src_is_main`, which rises too early or too late. A counter that is not cleared on abort has the same effect. This is seen within one wait, so for a crystal mode a 1024-cycle error is exposed about 8 us after the clear. A corrupted enable pair shows up at `sys_clk` within a few source periods: either a short phase, a stopped clock longer than one secondary period, or the wrong period once the move has settled. A done flag that is missing, repeated or the wrong width is seen on the same handover that should have produced it.

// File: rtl/osc_switch_seq.sv
module osc_switch_seq #(
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned LOCK_CYC = 4096,
  parameter int unsigned RC_CYC   = 8
) (
  input  logic       rst_n,
  input  logic       sec_clk,
  input  logic       main_clk,
  input  logic       pll_clk,
  input  logic [2:0] mode,
  input  logic       sel_sec,
  output logic       sys_clk,
  output logic       switch_done,
  output logic       src_is_main
);

  localparam int unsigned MAX_AB  = (OST_CYC > LOCK_CYC) ? OST_CYC : LOCK_CYC;
  localparam int unsigned CNT_MAX = (MAX_AB > RC_CYC) ? MAX_AB : RC_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {W_MAIN, W_SEC, W_OST, W_LOCK} wst_t;

  logic          use_pll, rc_mode, fclk, sel_m;
  logic [1:0]    sel_sync;
  wst_t          st;
  logic [CW-1:0] cnt, first_lim;
  logic          ready;
  logic [1:0]    f_sync, s_sync;
  logic          en_fast, en_fast_q, done_f;
  logic          en_sec, en_sec_q, done_s;

  assign use_pll   = (mode == 3'b101);
  assign rc_mode   = ~mode[2];
  assign fclk      = use_pll ? pll_clk : main_clk;
  assign sel_m     = sel_sync[1];
  assign first_lim = rc_mode ? CW'(RC_CYC - 1) : CW'(OST_CYC - 1);

  always_ff @(posedge main_clk or negedge rst_n)
    if (!rst_n) sel_sync <= 2'b00;
    else        sel_sync <= {sel_sync[0], sel_sec};

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_MAIN;
      cnt   <= '0;
      ready <= 1'b1;
    end else if (sel_m) begin
      st    <= W_SEC;
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      case (st)
        W_SEC: begin
          st  <= W_OST;
          cnt <= '0;
        end
        W_OST:
          if (cnt == first_lim) begin
            cnt <= '0;
            if (use_pll) st <= W_LOCK;
            else begin
              st    <= W_MAIN;
              ready <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        W_LOCK:
          if (cnt == CW'(LOCK_CYC - 1)) begin
            cnt   <= '0;
            st    <= W_MAIN;
            ready <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge fclk or negedge rst_n)
    if (!rst_n) begin
      f_sync    <= 2'b11;
      en_fast_q <= 1'b1;
      done_f    <= 1'b0;
    end else begin
      f_sync    <= {f_sync[0], ready & ~en_sec};
      en_fast_q <= en_fast;
      done_f    <= en_fast & ~en_fast_q;
    end

  always_ff @(negedge fclk or negedge rst_n)
    if (!rst_n) en_fast <= 1'b1;
    else        en_fast <= f_sync[1];

  always_ff @(posedge sec_clk or negedge rst_n)
    if (!rst_n) begin
      s_sync   <= 2'b00;
      en_sec_q <= 1'b0;
      done_s   <= 1'b0;
    end else begin
      s_sync   <= {s_sync[0], ~ready & ~en_fast};
      en_sec_q <= en_sec;
      done_s   <= en_sec & ~en_sec_q;
    end

  always_ff @(negedge sec_clk or negedge rst_n)
    if (!rst_n) en_sec <= 1'b0;
    else        en_sec <= s_sync[1];

  assign sys_clk     = (sec_clk & en_sec) | (fclk & en_fast);
  assign switch_done = done_f | done_s;
  assign src_is_main = en_fast;

endmodule

// File: rtl/osc_switch_seq_chk.sv
module osc_switch_seq_chk #(
  parameter int unsigned CW      = 11,
  parameter int unsigned CNT_MAX = 1024
) (
  input logic          rst_n,
  input logic          main_clk,
  input logic          fclk,
  input logic          sel_m,
  input logic          ready,
  input logic [CW-1:0] cnt,
  input logic          en_fast,
  input logic          en_sec,
  input logic          switch_done
);

  assert_never_both_R7: assert property (@(posedge main_clk) disable iff (!rst_n)
    !(en_fast && en_sec));

  assert_abort_drops_ready_R9: assert property (@(posedge main_clk) disable iff (!rst_n)
    sel_m |=> !ready);

  assert_min_wait_R3: assert property (@(posedge main_clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!sel_m, 8));

  assert_done_follows_R8: assert property (@(posedge fclk) disable iff (!rst_n)
    $rose(en_fast) |=> switch_done);

  assert_cnt_range_R4: assert property (@(posedge main_clk) disable iff (!rst_n)
    cnt < CW'(CNT_MAX));

endmodule

bind osc_switch_seq osc_switch_seq_chk #(.CW(CW), .CNT_MAX(CNT_MAX)) u_chk (
  .rst_n(rst_n), .main_clk(main_clk), .fclk(fclk), .sel_m(sel_m), .ready(ready),
  .cnt(cnt), .en_fast(en_fast), .en_sec(en_sec), .switch_done(switch_done)
);

// File: tb/osc_switch_seq_bench.sv
`timescale 1ns/100ps
module osc_switch_seq_bench;
  localparam int  OST  = 1024;
  localparam int  LOCK = 100;
  localparam int  RCN  = 8;
  localparam real TM = 8.0, TP = 4.0, TS = 100.0;

  logic rst_n = 0, sec_clk = 0, main_clk = 0, pll_clk = 0, sel_sec = 0;
  logic [2:0] mode = 3'b000;
  logic sys_clk, switch_done, src_is_main;

  int  checks = 0, errors = 0, done_cnt = 0, rise_cnt = 0;
  real last_edge = -1.0e9, last_rise = -1.0, min_phase = 1.0e9, max_gap = 0.0;
  real done_t = 0.0, done_w = 0.0;

  osc_switch_seq #(.OST_CYC(OST), .LOCK_CYC(LOCK), .RC_CYC(RCN)) u_osc_switch_seq (
    .rst_n(rst_n), .sec_clk(sec_clk), .main_clk(main_clk), .pll_clk(pll_clk),
    .mode(mode), .sel_sec(sel_sec), .sys_clk(sys_clk), .switch_done(switch_done),
    .src_is_main(src_is_main));

  always #4 main_clk = ~main_clk;
  always #2 pll_clk = ~pll_clk;
  initial begin #1; forever #50 sec_clk = ~sec_clk; end

  always @(sys_clk) begin
    if ($realtime - last_edge < min_phase) min_phase = $realtime - last_edge;
    last_edge = $realtime;
    if (sys_clk === 1'b1) begin
      if (last_rise >= 0.0 && $realtime - last_rise > max_gap) max_gap = $realtime - last_rise;
      last_rise = $realtime;
    end
  end
  always @(posedge switch_done) begin done_cnt++; done_t = $realtime; end
  always @(negedge switch_done) done_w = $realtime - done_t;
  always @(posedge src_is_main) rise_cnt++;

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic clear_track();
    last_edge = -1.0e9; last_rise = -1.0; min_phase = 1.0e9; max_gap = 0.0;
    done_cnt = 0; rise_cnt = 0;
  endtask

  task automatic sys_period(output real p);
    real t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = $realtime - t0;
  endtask

  function automatic bit near(input real a, input real b);
    return (a > b - 0.01) && (a < b + 0.01);
  endfunction

  task automatic do_reset(input logic [2:0] m, input real per);
    real p;
    rst_n = 0; sel_sec = 0; mode = m;
    #50; clear_track(); rst_n = 1; #200;
    chk(src_is_main == 1'b1, "R1", "status after reset", real'(src_is_main), 1.0);
    chk(switch_done == 1'b0, "R1", "done after reset", real'(switch_done), 0.0);
    chk(done_cnt == 0, "R1", "done pulses after reset", real'(done_cnt), 0.0);
    sys_period(p);
    chk(near(p, per), "R1", "period after reset", p, per);
  endtask

  task automatic to_sec(input real old_per);
    real tr, d, p;
    int k = 0;
    clear_track(); tr = $realtime; sel_sec = 1;
    while (done_cnt < 1 && k < 2000) begin #1; k++; end
    d = $realtime - tr;
    chk(d <= 4 * TS + 6 * TM, "R2", "secondary handover time", d, 4 * TS + 6 * TM);
    #300;
    chk(src_is_main == 1'b0, "R2", "status on secondary", real'(src_is_main), 0.0);
    sys_period(p);
    chk(near(p, TS), "R2", "secondary period", p, TS);
    chk(done_cnt == 1, "R8", "done pulses to secondary", real'(done_cnt), 1.0);
    chk(near(done_w, TS), "R8", "done width secondary", done_w, TS);
    chk(min_phase >= old_per / 2 - 0.01, "R7", "min phase to secondary", min_phase, old_per / 2);
  endtask

  task automatic to_main(input int n, input real per, input string req);
    real tf, d, p;
    int k = 0;
    clear_track(); tf = $realtime; sel_sec = 0;
    while (!src_is_main && k < n * 8 + 2000) begin #1; k++; end
    d = $realtime - tf;
    chk(d >= n * TM, req, "handover not before wait", d, n * TM);
    chk(d <= n * TM + 4 * TS + 6 * TM, req, "handover within bound", d, n * TM + 4 * TS + 6 * TM);
    #400;
    sys_period(p);
    chk(near(p, per), req, "fast period", p, per);
    chk(done_cnt == 1, "R8", "done pulses to fast", real'(done_cnt), 1.0);
    chk(near(done_w, per), "R8", "done width fast", done_w, per);
    chk(min_phase >= per / 2 - 0.01, "R7", "min phase to fast", min_phase, per / 2);
    chk(max_gap <= TS + 0.01, "R6", "max gap between rising edges", max_gap, TS);
  endtask

  task automatic abort_test();
    real p;
    clear_track(); sel_sec = 0;
    #(500 * 8);
    sel_sec = 1;
    #(1500 * 8);
    chk(rise_cnt == 0, "R9", "status rises on abort", real'(rise_cnt), 0.0);
    chk(done_cnt == 0, "R9", "done pulses on abort", real'(done_cnt), 0.0);
    sys_period(p);
    chk(near(p, TS), "R9", "period after abort", p, TS);
    chk(max_gap <= TS + 0.01, "R6", "gap during abort", max_gap, TS);
    to_main(OST, TM, "R9");
  endtask

  initial begin : watchdog
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(3'b000, TM);
    do_reset(3'b101, TP);
    to_sec(TP);
    to_main(OST + LOCK, TP, "R5");
    do_reset(3'b000, TM);
    to_sec(TM);
    to_main(RCN, TM, "R3");
    for (int m = 1; m < 4; m++) begin
      to_sec(TM);
      mode = 3'(m);
      to_main(RCN, TM, "R3");
    end
    to_sec(TM);
    mode = 3'b100;
    to_main(OST, TM, "R4");
    to_sec(TM);
    abort_test();
    to_sec(TM);
    mode = 3'b111;
    to_main(OST, TM, "R10");
    to_sec(TM);
    mode = 3'b110;
    to_main(OST, TM, "R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule